// File: doc/BRIEF.md
# Vectored Two-Line Interrupt Controller

This block gathers level-sensitive interrupt requests from a parameterised set of peripheral sources (nineteen by default) and turns them into two processor request lines: a fast, high-priority line and a normal-priority line. Each source can also be raised by software through a private request bit, which is ORed with the hardware input. A per-source enable mask qualifies the requests, a per-source routing bit steers each one to one of the two lines, and a 4-bit priority per source picks the winner on each line.

For each line the controller presents a registered vector, the index of the source that should be served. A per-line threshold supports nested service. Software raises the threshold to the priority of the handler it is running, so only strictly more urgent sources can assert that line again. All state is reached through a small word-addressed register port with single-cycle writes and combinational reads.

Two identical line arbiters sit under the top, one for each line, next to a register file that holds the masks, priorities, thresholds and software requests.

Top module: `vic_top`

## Requirements
- R1: The raw status word (address 0x00, bit i = source i) reads the hardware request ORed with the software request bit, before any masking.
- R2: The pending word (address 0x01) reads the raw status ANDed with the enable mask (address 0x02, bit i enables source i).
- R3: Routing word (address 0x03): bit i = 1 sends source i to the fast line, 0 sends it to the normal line. A source never asserts the line it is not routed to.
- R4: A line's vector (fast at 0x09, normal at 0x0A, also on the vector ports) is the index of the enabled, pending source on that line with the highest priority. When priorities are equal, the lowest index wins.
- R5: A source can assert a line only when its priority is strictly greater than that line's threshold (fast at 0x07, normal at 0x08, low 4 bits). A priority equal to the threshold does not qualify.
- R6: With no qualifying source, a line is low and its vector reads the all-ones code (31 for the default 19 sources).
- R7: Lines and vectors are registered, so a change at the inputs or in a register appears at the outputs after exactly one clock edge.
- R8: Writing address 0x04 sets the software request bits that are 1 in the data, and writing 0x05 clears them. Bits written as 0 keep their value. The bits read back at 0x06, and 0x04 and 0x05 read as zero.
- R9: Requests are level-sensitive. When a source's input and its software bit are both low, it stops being pending and its line drops one edge later.
- R10: After reset, the enables, routing, priorities, thresholds and software bits are all zero, both lines are low and both vectors hold the all-ones code.
- R11: Source i's priority lives at address 0x20 + i in the low 4 bits and reads back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_req_i | input | NUM_SRC | Level request from each peripheral |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Word address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i (combinational) |
| irq_fast_o | output | 1 | Fast high-priority request line |
| irq_norm_o | output | 1 | Normal-priority request line |
| vec_fast_o | output | VEC_W | Source index for the fast line |
| vec_norm_o | output | VEC_W | Source index for the normal line |

## Verification
The embedded assertions watch every cycle for the following conditions. A raised line must name a source that was a candidate on that line one cycle earlier. That source's priority must have beaten the threshold. A line must stay low when there were no candidates. The two lines must never present the same source. Software set and clear writes must take effect on exactly the written bits. Lowest-index tie-breaking, the exact one-edge latency, the all-ones idle code read through the register port, the effect of a threshold equal to the priority, and the reset values can only be shown by the directed scenarios, which compare the register reads and output pins with hand-computed values.

// File: rtl/vic_pkg.sv
package vic_pkg;
    localparam int unsigned PRIO_W = 4;

    localparam logic [5:0] A_RAW    = 6'h00;
    localparam logic [5:0] A_PEND   = 6'h01;
    localparam logic [5:0] A_ENABLE = 6'h02;
    localparam logic [5:0] A_ROUTE  = 6'h03;
    localparam logic [5:0] A_SWSET  = 6'h04;
    localparam logic [5:0] A_SWCLR  = 6'h05;
    localparam logic [5:0] A_SWREQ  = 6'h06;
    localparam logic [5:0] A_THR_F  = 6'h07;
    localparam logic [5:0] A_THR_N  = 6'h08;
    localparam logic [5:0] A_VEC_F  = 6'h09;
    localparam logic [5:0] A_VEC_N  = 6'h0A;
    localparam logic [5:0] A_PRIO0  = 6'h20;

    typedef enum logic {
        LINE_NORM = 1'b0,
        LINE_FAST = 1'b1
    } line_e;
endpackage

// File: rtl/vic_regs.sv
module vic_regs
    import vic_pkg::*;
#(
    parameter int unsigned NUM_SRC = 19,
    parameter int unsigned ADDR_W  = 6,
    parameter int unsigned VEC_W   = 5
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       we_i,
    input  logic [ADDR_W-1:0]          addr_i,
    input  logic [31:0]                wdata_i,
    output logic [31:0]                rdata_o,
    input  logic [NUM_SRC-1:0]         hw_req_i,
    input  logic [VEC_W-1:0]           vec_fast_i,
    input  logic [VEC_W-1:0]           vec_norm_i,
    output logic [NUM_SRC-1:0]         pend_o,
    output logic [NUM_SRC-1:0]         route_o,
    output logic [NUM_SRC*PRIO_W-1:0]  prio_o,
    output logic [PRIO_W-1:0]          thr_fast_o,
    output logic [PRIO_W-1:0]          thr_norm_o
);
    logic [NUM_SRC-1:0] en_q;
    logic [NUM_SRC-1:0] route_q;
    logic [NUM_SRC-1:0] sw_q;
    logic [PRIO_W-1:0]  thr_f_q;
    logic [PRIO_W-1:0]  thr_n_q;
    logic [NUM_SRC-1:0] raw;

    localparam logic [ADDR_W-1:0] W_RAW    = ADDR_W'(A_RAW);
    localparam logic [ADDR_W-1:0] W_PEND   = ADDR_W'(A_PEND);
    localparam logic [ADDR_W-1:0] W_ENABLE = ADDR_W'(A_ENABLE);
    localparam logic [ADDR_W-1:0] W_ROUTE  = ADDR_W'(A_ROUTE);
    localparam logic [ADDR_W-1:0] W_SWSET  = ADDR_W'(A_SWSET);
    localparam logic [ADDR_W-1:0] W_SWCLR  = ADDR_W'(A_SWCLR);
    localparam logic [ADDR_W-1:0] W_SWREQ  = ADDR_W'(A_SWREQ);
    localparam logic [ADDR_W-1:0] W_THR_F  = ADDR_W'(A_THR_F);
    localparam logic [ADDR_W-1:0] W_THR_N  = ADDR_W'(A_THR_N);
    localparam logic [ADDR_W-1:0] W_VEC_F  = ADDR_W'(A_VEC_F);
    localparam logic [ADDR_W-1:0] W_VEC_N  = ADDR_W'(A_VEC_N);

    assign raw        = hw_req_i | sw_q;
    assign pend_o     = raw & en_q;
    assign route_o    = route_q;
    assign thr_fast_o = thr_f_q;
    assign thr_norm_o = thr_n_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q    <= '0;
            route_q <= '0;
            sw_q    <= '0;
            thr_f_q <= '0;
            thr_n_q <= '0;
        end else if (we_i) begin
            case (addr_i)
                W_ENABLE: en_q    <= wdata_i[NUM_SRC-1:0];
                W_ROUTE:  route_q <= wdata_i[NUM_SRC-1:0];
                W_SWSET:  sw_q    <= sw_q | wdata_i[NUM_SRC-1:0];
                W_SWCLR:  sw_q    <= sw_q & ~wdata_i[NUM_SRC-1:0];
                W_THR_F:  thr_f_q <= wdata_i[PRIO_W-1:0];
                W_THR_N:  thr_n_q <= wdata_i[PRIO_W-1:0];
                default:  ;
            endcase
        end
    end

    generate
        for (genvar s = 0; s < NUM_SRC; s++) begin : g_prio
            localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(int'(A_PRIO0) + s);
            logic [PRIO_W-1:0] p_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    p_q <= '0;
                end else if (we_i && addr_i == MY_ADDR) begin
                    p_q <= wdata_i[PRIO_W-1:0];
                end
            end
            assign prio_o[s*PRIO_W +: PRIO_W] = p_q;
        end
    endgenerate

    always_comb begin
        rdata_o = '0;
        case (addr_i)
            W_RAW:    rdata_o[NUM_SRC-1:0] = raw;
            W_PEND:   rdata_o[NUM_SRC-1:0] = pend_o;
            W_ENABLE: rdata_o[NUM_SRC-1:0] = en_q;
            W_ROUTE:  rdata_o[NUM_SRC-1:0] = route_q;
            W_SWREQ:  rdata_o[NUM_SRC-1:0] = sw_q;
            W_THR_F:  rdata_o[PRIO_W-1:0]  = thr_f_q;
            W_THR_N:  rdata_o[PRIO_W-1:0]  = thr_n_q;
            W_VEC_F:  rdata_o[VEC_W-1:0]   = vec_fast_i;
            W_VEC_N:  rdata_o[VEC_W-1:0]   = vec_norm_i;
            default: begin
                for (int s = 0; s < NUM_SRC; s++) begin
                    if (addr_i == ADDR_W'(int'(A_PRIO0) + s)) begin
                        rdata_o[PRIO_W-1:0] = prio_o[s*PRIO_W +: PRIO_W];
                    end
                end
            end
        endcase
    end

    // R8
    swset_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && addr_i == W_SWSET) |=>
        ((sw_q & $past(wdata_i[NUM_SRC-1:0])) == $past(wdata_i[NUM_SRC-1:0])));

    // R8
    swclr_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && addr_i == W_SWCLR) |=>
        ((sw_q & $past(wdata_i[NUM_SRC-1:0])) == '0));
endmodule

// File: rtl/vic_arb.sv
module vic_arb
    import vic_pkg::*;
#(
    parameter int unsigned NUM_SRC = 19,
    parameter int unsigned VEC_W   = 5
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_SRC-1:0]        cand_i,
    input  logic [NUM_SRC*PRIO_W-1:0] prio_i,
    input  logic [PRIO_W-1:0]         thr_i,
    output logic                      irq_o,
    output logic [VEC_W-1:0]          vec_o
);
    localparam logic [VEC_W-1:0] NO_IRQ = '1;

    logic [PRIO_W-1:0] best_p;
    logic [VEC_W-1:0]  best_v;
    logic              hit;

    always_comb begin
        best_p = thr_i;
        best_v = NO_IRQ;
        hit    = 1'b0;
        for (int s = 0; s < NUM_SRC; s++) begin
            if (cand_i[s] && prio_i[s*PRIO_W +: PRIO_W] > best_p) begin
                best_p = prio_i[s*PRIO_W +: PRIO_W];
                best_v = VEC_W'(s);
                hit    = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_o <= 1'b0;
            vec_o <= NO_IRQ;
        end else begin
            irq_o <= hit;
            vec_o <= best_v;
        end
    end

    logic [NUM_SRC-1:0]        cand_d;
    logic [NUM_SRC*PRIO_W-1:0] prio_d;
    logic [PRIO_W-1:0]         thr_d;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cand_d <= '0;
            prio_d <= '0;
            thr_d  <= '0;
        end else begin
            cand_d <= cand_i;
            prio_d <= prio_i;
            thr_d  <= thr_i;
        end
    end

    // R6
    idle_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cand_i == '0) |=> !irq_o);

    // R4
    winner_cand_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> cand_d[vec_o]);

    // R5
    above_thr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (prio_d[32'(vec_o)*PRIO_W +: PRIO_W] > thr_d));
endmodule

// File: rtl/vic_top.sv
module vic_top
    import vic_pkg::*;
#(
    parameter int unsigned NUM_SRC = 19,
    parameter int unsigned ADDR_W  = 6,
    localparam int unsigned VEC_W  = $clog2(NUM_SRC + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_req_i,
    input  logic               reg_we_i,
    input  logic [ADDR_W-1:0]  reg_addr_i,
    input  logic [31:0]        reg_wdata_i,
    output logic [31:0]        reg_rdata_o,
    output logic               irq_fast_o,
    output logic               irq_norm_o,
    output logic [VEC_W-1:0]   vec_fast_o,
    output logic [VEC_W-1:0]   vec_norm_o
);
    logic [NUM_SRC-1:0]        pend;
    logic [NUM_SRC-1:0]        route;
    logic [NUM_SRC*PRIO_W-1:0] prio;
    logic [PRIO_W-1:0]         thr [2];
    logic [NUM_SRC-1:0]        cand [2];
    logic                      irq [2];
    logic [VEC_W-1:0]          vec [2];

    vic_regs #(
        .NUM_SRC (NUM_SRC),
        .ADDR_W  (ADDR_W),
        .VEC_W   (VEC_W)
    ) regs_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .we_i       (reg_we_i),
        .addr_i     (reg_addr_i),
        .wdata_i    (reg_wdata_i),
        .rdata_o    (reg_rdata_o),
        .hw_req_i   (src_req_i),
        .vec_fast_i (vec[LINE_FAST]),
        .vec_norm_i (vec[LINE_NORM]),
        .pend_o     (pend),
        .route_o    (route),
        .prio_o     (prio),
        .thr_fast_o (thr[LINE_FAST]),
        .thr_norm_o (thr[LINE_NORM])
    );

    generate
        for (genvar l = 0; l < 2; l++) begin : g_line
            if (l == int'(LINE_FAST)) begin : g_sel
                assign cand[l] = pend & route;
            end else begin : g_sel
                assign cand[l] = pend & ~route;
            end
            vic_arb #(
                .NUM_SRC (NUM_SRC),
                .VEC_W   (VEC_W)
            ) arb_i (
                .clk    (clk),
                .rst_n  (rst_n),
                .cand_i (cand[l]),
                .prio_i (prio),
                .thr_i  (thr[l]),
                .irq_o  (irq[l]),
                .vec_o  (vec[l])
            );
        end
    endgenerate

    assign irq_fast_o = irq[LINE_FAST];
    assign irq_norm_o = irq[LINE_NORM];
    assign vec_fast_o = vec[LINE_FAST];
    assign vec_norm_o = vec[LINE_NORM];

    // R3
    split_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_fast_o && irq_norm_o) |-> (vec_fast_o != vec_norm_o));
endmodule

// File: tb/vic_top_tb_top.sv
module vic_top_tb_top;
    localparam int NUM_SRC = 19;
    localparam int ADDR_W  = 6;
    localparam int VEC_W   = 5;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [NUM_SRC-1:0] src_req = '0;
    logic               we = 1'b0;
    logic [ADDR_W-1:0]  addr = '0;
    logic [31:0]        wdata = '0;
    logic [31:0]        rdata;
    logic               irq_f, irq_n;
    logic [VEC_W-1:0]   vec_f, vec_n;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    vic_top #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .src_req_i   (src_req),
        .reg_we_i    (we),
        .reg_addr_i  (addr),
        .reg_wdata_i (wdata),
        .reg_rdata_o (rdata),
        .irq_fast_o  (irq_f),
        .irq_norm_o  (irq_n),
        .vec_fast_o  (vec_f),
        .vec_norm_o  (vec_n)
    );

    task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", rq, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        addr = ADDR_W'(a); wdata = d; we = 1'b1;
        @(posedge clk); #1;
        we = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        addr = ADDR_W'(a); #1;
        d = rdata;
    endtask

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        check("R10 fast line", {31'd0, irq_f}, 0);
        check("R10 norm line", {31'd0, irq_n}, 0);
        check("R10 fast vec", 32'(vec_f), 31);
        check("R10 norm vec", 32'(vec_n), 31);
        rd(6'h02, d); check("R10 enable", d, 0);
        rd(6'h03, d); check("R10 route", d, 0);
        rd(6'h06, d); check("R10 swreq", d, 0);
        rd(6'h25, d); check("R10 prio5", d, 0);
        rd(6'h09, d); check("R6 fast vec reg idle", d, 31);
    endtask

    task automatic t_status();
        logic [31:0] d;
        src_req = 19'h00028;
        wr(6'h02, 32'h8);
        rd(6'h00, d); check("R1 raw", d, 32'h28);
        rd(6'h01, d); check("R2 pend", d, 32'h08);
        tick();
        check("R5 prio0 thr0 no line", {31'd0, irq_n}, 0);
    endtask

    task automatic t_route_vec();
        logic [31:0] d;
        wr(6'h23, 5); wr(6'h25, 5); wr(6'h27, 9);
        rd(6'h27, d); check("R11 prio readback", d, 9);
        wr(6'h02, 32'hA8);
        wr(6'h03, 32'h80);
        src_req = 19'h000A8;
        tick();
        check("R3 fast line", {31'd0, irq_f}, 1);
        check("R3 fast vec", 32'(vec_f), 7);
        check("R4 tie lowest idx", 32'(vec_n), 3);
        rd(6'h0A, d); check("R4 norm vec reg", d, 3);
    endtask

    task automatic t_threshold();
        wr(6'h08, 5);
        tick();
        check("R5 equal thr blocks", {31'd0, irq_n}, 0);
        check("R6 idle code", 32'(vec_n), 31);
        check("R3 fast unaffected", 32'(vec_f), 7);
        wr(6'h08, 4);
        tick();
        check("R5 above thr", 32'(vec_n), 3);
    endtask

    task automatic t_latency();
        wr(6'h2A, 15);
        wr(6'h02, 32'h4A8);
        tick();
        @(negedge clk);
        src_req = 19'h004A8;
        #1;
        check("R7 before edge", 32'(vec_n), 3);
        tick();
        check("R7 after one edge", 32'(vec_n), 10);
        src_req = 19'h000A8;
        tick();
        check("R9 level drop", 32'(vec_n), 3);
    endtask

    task automatic t_software();
        logic [31:0] d;
        src_req = '0;
        wr(6'h08, 0);
        wr(6'h2C, 2);
        wr(6'h02, 32'h1002);
        wr(6'h04, 32'h1000);
        tick();
        rd(6'h00, d); check("R1 raw sw", d, 32'h1000);
        check("R8 sw vec", 32'(vec_n), 12);
        wr(6'h04, 32'h2);
        rd(6'h06, d); check("R8 set keeps", d, 32'h1002);
        rd(6'h04, d); check("R8 set reads 0", d, 0);
        wr(6'h05, 32'h1000);
        rd(6'h06, d); check("R8 clr keeps", d, 32'h2);
        tick();
        check("R9 sw drop", {31'd0, irq_n}, 0);
        wr(6'h05, 32'h2);
    endtask

    task automatic t_last_src();
        wr(6'h32, 15);
        wr(6'h02, 32'h40000);
        wr(6'h03, 32'h40000);
        src_req = 19'h40000;
        tick();
        check("R4 last index fast", 32'(vec_f), 18);
        check("R3 norm idle", {31'd0, irq_n}, 0);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        #12 rst_n = 1'b1;
        tick();
        t_reset();
        t_status();
        t_route_vec();
        t_threshold();
        t_latency();
        t_software();
        t_last_src();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule